// File: doc/BRIEF.md
# Bidirectional Stack Pointer Register

This block holds the stack pointer of a small CPU built around one shared data bus and a 256-byte address space. The pointer is a register. Software writes it from the bus and can read it back onto the bus, which lets it be copied to and from an index register. It also moves by exactly one position when a count strobe is given. The direction of that move comes from a separate two-bit control field, which the microcode shares with other units.

The stack grows toward lower addresses, and the pointer always names the next free slot. The microcode builds a push from three steps: expose the pointer to the address register, write memory, then give a count strobe with the "down" code. A pull starts with a count strobe using the "up" code, then exposes the new pointer and reads memory. Because the block has no reset, its contents are undefined until the first load. Software alone keeps the stack inside its chosen region, and the block reports no overflow.

Top module: `stack_ptr`

## Requirements
- R1: While `readEn` is 0, `busOut` is 0x00. While `readEn` is 1, `busOut` shows the current pointer in the same cycle.
- R2: When `loadEn` is 1 at a rising clock edge, the pointer takes the value of `busIn`.
- R3: Load takes priority over counting. With `loadEn` and `countEn` both 1, the pointer takes `busIn` and no step is applied.
- R4: When `countEn` is 1 and `dirCode` is 2'b01 (down, used after a push write), the pointer decreases by one at the clock edge.
- R5: When `countEn` is 1 and `dirCode` is 2'b10 (up, used before a pull read), the pointer increases by one at the clock edge.
- R6: Counting wraps modulo 256: down from 0x00 gives 0xFF, and up from 0xFF gives 0x00.
- R7: When `countEn` is 1 and `dirCode` is 2'b00 or 2'b11 (codes owned by other units), the pointer is unchanged.
- R8: With neither `loadEn` nor `countEn` asserted, the pointer holds its value.
- R9: `busDrive` is 1 exactly while `readEn` is 1. The bus multiplexer uses it to select this source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| busIn | input | 8 | Value on the shared data bus, used for loads |
| loadEn | input | 1 | Write the pointer from the bus |
| countEn | input | 1 | Step the pointer once in the direction given by `dirCode` |
| dirCode | input | 2 | Shared control field: 01 = down, 10 = up, others = no step |
| readEn | input | 1 | Put the pointer on the bus |
| busOut | output | 8 | Gated pointer value for the bus multiplexer |
| busDrive | output | 1 | This block is the active bus source |

## Verification
The step and hold properties assume the pointer has been loaded at least once. Before that, its value is undefined. The checker therefore keeps every clocked property disabled until it has seen a load, and the stimulus always begins with a load before any count. The properties also assume that `dirCode` only matters while `countEn` is high. To match this, the stimulus drives the codes owned by other units together with a count strobe, which shows that those codes cause no step.

// File: rtl/stack_ptr_pkg.sv
package stack_ptr_pkg;

  // Direction codes on the shared two-bit control field
  localparam logic [1:0] DIR_DOWN = 2'b01;
  localparam logic [1:0] DIR_UP   = 2'b10;

  typedef struct packed {
    logic load;
    logic stepUp;
    logic stepDown;
    logic drive;
  } spStrobes_t;

endpackage

// File: rtl/stack_ptr_ctrl.sv
module stack_ptr_ctrl
  import stack_ptr_pkg::*;
(
  input  logic       loadEn,
  input  logic       countEn,
  input  logic [1:0] dirCode,
  input  logic       readEn,
  output spStrobes_t strobes
);

  logic countDown;
  logic countUp;

  // Only the two step codes belong to this block; others are for neighbours
  always_comb begin
    countDown = countEn && (dirCode == DIR_DOWN);
    countUp   = countEn && (dirCode == DIR_UP);
  end

  // Load suppresses any count in the same step
  always_comb begin
    strobes.load     = loadEn;
    strobes.stepUp   = countUp   && !loadEn;
    strobes.stepDown = countDown && !loadEn;
    strobes.drive    = readEn;
  end

endmodule

// File: rtl/stack_ptr_datapath.sv
module stack_ptr_datapath
  import stack_ptr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  spStrobes_t   strobes,
  input  logic [W-1:0] busIn,
  output logic [W-1:0] ptrVal,
  output logic [W-1:0] busOut,
  output logic         busDrive
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] ptrQ;
  logic [W-1:0] ptrNext;
  logic [W-1:0] ptrInc;
  logic [W-1:0] ptrDec;

  assign ptrInc = ptrQ + ONE;
  assign ptrDec = ptrQ - ONE;

  always_comb begin
    ptrNext = ptrQ;
    if (strobes.load)          ptrNext = busIn;
    else if (strobes.stepUp)   ptrNext = ptrInc;
    else if (strobes.stepDown) ptrNext = ptrDec;
  end

  // No reset: contents are undefined until the first load
  always_ff @(posedge clk) begin
    ptrQ <= ptrNext;
  end

  assign ptrVal   = ptrQ;
  assign busOut   = strobes.drive ? ptrQ : ZERO;
  assign busDrive = strobes.drive;

endmodule

// File: rtl/stack_ptr.sv
module stack_ptr
  import stack_ptr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] busIn,
  input  logic         loadEn,
  input  logic         countEn,
  input  logic [1:0]   dirCode,
  input  logic         readEn,
  output logic [W-1:0] busOut,
  output logic         busDrive
);

  spStrobes_t   strobes;
  logic [W-1:0] ptrVal;

  stack_ptr_ctrl u_ctrl (
    .loadEn  (loadEn),
    .countEn (countEn),
    .dirCode (dirCode),
    .readEn  (readEn),
    .strobes (strobes)
  );

  stack_ptr_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .busIn    (busIn),
    .ptrVal   (ptrVal),
    .busOut   (busOut),
    .busDrive (busDrive)
  );

endmodule

// File: rtl/stack_ptr_chk.sv
module stack_ptr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic [W-1:0] busIn,
  input logic         loadEn,
  input logic         countEn,
  input logic [1:0]   dirCode,
  input logic         readEn,
  input logic [W-1:0] busOut,
  input logic         busDrive,
  input logic [W-1:0] ptrVal
);

  // Properties stay off until the pointer holds a defined value
  logic loadedSeen = 1'b0;
  always_ff @(posedge clk) begin
    if (loadEn) loadedSeen <= 1'b1;
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    loadEn |=> ptrVal == $past(busIn));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    (countEn && !loadEn && dirCode == 2'b01) |=> ptrVal == W'($past(ptrVal) - W'(1)));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!loadEn && !loadedSeen)
    (countEn && !loadEn && dirCode == 2'b10) |=> ptrVal == W'($past(ptrVal) + W'(1)));

  // R7
  foreign_code_hold_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    (countEn && !loadEn && (dirCode == 2'b00 || dirCode == 2'b11)) |=> $stable(ptrVal));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    (!countEn && !loadEn) |=> $stable(ptrVal));

  // R1
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    !readEn |-> busOut == '0);

  // R9
  drive_flag_chk: assert property (@(posedge clk) disable iff (!loadedSeen)
    busDrive == readEn);

endmodule

bind stack_ptr stack_ptr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .busIn    (busIn),
  .loadEn   (loadEn),
  .countEn  (countEn),
  .dirCode  (dirCode),
  .readEn   (readEn),
  .busOut   (busOut),
  .busDrive (busDrive),
  .ptrVal   (ptrVal)
);

// File: tb/stack_ptr_bench.sv
module stack_ptr_bench;

  logic       clk = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic       loadEn = 1'b0;
  logic       countEn = 1'b0;
  logic [1:0] dirCode = 2'b00;
  logic       readEn = 1'b0;
  logic [7:0] busOut;
  logic       busDrive;

  int applied = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  stack_ptr u_stack_ptr (
    .clk      (clk),
    .busIn    (busIn),
    .loadEn   (loadEn),
    .countEn  (countEn),
    .dirCode  (dirCode),
    .readEn   (readEn),
    .busOut   (busOut),
    .busDrive (busDrive)
  );

  typedef struct packed {
    logic       ld;
    logic       ce;
    logic [1:0] dir;
    logic [7:0] din;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'b00, 8'h80, 8'h80, 8'd2}, // R2 load
    '{1'b0, 1'b1, 2'b01, 8'h00, 8'h7F, 8'd4}, // R4 down
    '{1'b0, 1'b1, 2'b01, 8'h00, 8'h7E, 8'd4}, // R4 down
    '{1'b0, 1'b1, 2'b10, 8'h00, 8'h7F, 8'd5}, // R5 up
    '{1'b0, 1'b1, 2'b00, 8'h00, 8'h7F, 8'd7}, // R7 foreign code 00
    '{1'b0, 1'b1, 2'b11, 8'h00, 8'h7F, 8'd7}, // R7 foreign code 11
    '{1'b0, 1'b0, 2'b01, 8'h55, 8'h7F, 8'd8}, // R8 idle
    '{1'b1, 1'b1, 2'b01, 8'h10, 8'h10, 8'd3}, // R3 load beats down
    '{1'b1, 1'b0, 2'b00, 8'h00, 8'h00, 8'd2}, // R2 load
    '{1'b0, 1'b1, 2'b01, 8'h00, 8'hFF, 8'd6}, // R6 wrap down
    '{1'b0, 1'b1, 2'b10, 8'h00, 8'h00, 8'd6}, // R6 wrap up
    '{1'b1, 1'b0, 2'b00, 8'hFF, 8'hFF, 8'd2}, // R2 load
    '{1'b0, 1'b1, 2'b10, 8'h00, 8'h00, 8'd6}, // R6 wrap up
    '{1'b1, 1'b1, 2'b10, 8'h42, 8'h42, 8'd3}  // R3 load beats up
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic ce, input logic [1:0] dir, input logic [7:0] din);
    loadEn = ld; countEn = ce; dirCode = dir; busIn = din;
    @(negedge clk);
    loadEn = 1'b0; countEn = 1'b0; dirCode = 2'b00;
  endtask

  initial begin
    @(negedge clk);
    // R1 bus quiet with read off, before any load
    check(busOut, 8'h00, "R1");
    // R9 no drive flag with read off
    check({7'd0, busDrive}, 8'h00, "R9");

    readEn = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VECS[i].ld, VECS[i].ce, VECS[i].dir, VECS[i].din);
      check(busOut, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
    end
    // R9 drive flag while reading
    check({7'd0, busDrive}, 8'h01, "R9");

    // Push sequence from 0xF3: three pushes, then three pulls
    step(1'b1, 1'b0, 2'b00, 8'hF3);
    for (int i = 1; i <= 3; i++) begin
      step(1'b0, 1'b1, 2'b01, 8'h00);
      check(busOut, 8'hF3 - 8'(i), "R4");
    end
    for (int i = 1; i <= 3; i++) begin
      step(1'b0, 1'b1, 2'b10, 8'h00);
      check(busOut, 8'hF0 + 8'(i), "R5");
    end

    // R1 read off hides pointer, value retained and visible again
    readEn = 1'b0;
    #1;
    check(busOut, 8'h00, "R1");
    check({7'd0, busDrive}, 8'h00, "R9");
    step(1'b0, 1'b1, 2'b11, 8'h00);
    readEn = 1'b1;
    #1;
    check(busOut, 8'hF3, "R1");
    check(busOut, 8'hF3, "R7");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      applied++;
      misses++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end

endmodule